// File: doc/BRIEF.md
# Compare-Timer Channel

This block is a single timer channel. It compares a free-running 64-bit system count against a compare value that software programs. When the count has reached the compare value, the channel raises a status flag. If the channel is unmasked, it also drives a level interrupt. Software reaches the channel through a plain register port with two locations: a 64-bit compare register and a 3-bit control word. The control word holds an enable bit, a mask bit and the status flag, which software can only read.

The status flag reports the timer condition and nothing else. Masking silences the interrupt line but leaves the flag as it is. A handler that masks the line before passing the event on can therefore still see why the event happened.

When the count falls below the compare value, the flag and the line are both cleared. Disabling the channel drops the line and freezes the flag at its last value.

Top module: `cmp_timer_chan`

## Requirements
- R1: The timer condition is true when the count input is greater than or equal to the compare value, with equality counting as met.
- R2: While enable is 1, the status flag is updated on every clock edge from the count and the compare value. The mask bit has no effect on the flag.
- R3: The interrupt output is a register. Its next value is 1 only when enable is 1, mask is 0 and the condition is met. As a result, it follows a change of cause one cycle later.
- R4: Writing mask from 0 to 1 deasserts the interrupt on the following cycle and leaves the status flag at 1.
- R5: When the count falls below the compare value, for example after a higher compare value is written, the status flag becomes 0 and the interrupt deasserts.
- R6: Writing enable from 1 to 0 deasserts the interrupt. While enable is 0, the status flag holds its last value and does not follow the count.
- R7: The control word uses bit 0 for enable, bit 1 for mask and bit 2 for the status flag. A read returns all three bits. A write updates only bits 0 and 1, and the value written to bit 2 is ignored.
- R8: Clearing mask while enable and status are 1 asserts the interrupt again on the next cycle.
- R9: After reset, enable, mask, status, the compare value and the interrupt are all 0.
- R10: A compare write is readable at once. It is first used for the condition on the clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| count_i | input | 64 | Free-running system count |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = control word, 1 = compare value |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 1 | Read target: 0 = control word, 1 = compare value |
| rd_data_o | output | 64 | Read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench aims at the boundary where the count equals the compare value. A comparator that tested only strictly greater would stay silent there.

It masks a pending event and reads the control word back. A design that tied the flag to the mask would then report status 0, the same fault that confuses a handler downstream.

It rewrites the compare value above the count and checks the exact cycle of the clear. A design that cleared only the line, or that used the new value too early, would show the wrong flag or a shifted edge.

It also disables the channel while the flag is set and then moves the count. A design whose flag follows the count while disabled, or that leaves the line up, is caught this way.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  // Control word bit positions (software-visible layout)
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MASK_BIT = 1;
  localparam int unsigned CTL_STAT_BIT = 2;
  localparam int unsigned CTL_W        = 3;

  // Register select encodings
  localparam logic SEL_CTL = 1'b0;
  localparam logic SEL_CMP = 1'b1;

  typedef struct packed {
    logic en;
    logic mask;
  } ctl_rw_t;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output ctl_rw_t          ctl_o,
  output logic [CNT_W-1:0] cmp_o
);
  ctl_rw_t          ctl_q, ctl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             ctl_we, cmp_we;

  always_comb begin
    ctl_we = wr_en_i && (wr_sel_i == SEL_CTL);
    cmp_we = wr_en_i && (wr_sel_i == SEL_CMP);
    ctl_d  = ctl_q;
    cmp_d  = cmp_q;
    if (ctl_we) begin
      ctl_d.en   = wr_data_i[CTL_EN_BIT];
      ctl_d.mask = wr_data_i[CTL_MASK_BIT];
    end
    if (cmp_we) begin
      cmp_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      cmp_q <= cmp_d;
    end
  end

  assign ctl_o = ctl_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/cmp_timer_cond.sv
module cmp_timer_cond #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  output logic             cond_o,
  output logic             stat_o
);
  logic stat_q, stat_d;

  always_comb begin
    cond_o = (count_i >= cmp_i);
    // Disabled: the flag has no defined meaning, so it simply holds.
    stat_d = en_i ? cond_o : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic en_i,
  input  logic mask_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = en_i && !mask_i && cond_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             irq_o
);
  localparam int unsigned PAD_W = CNT_W - CTL_W;

  // Reset: asserted asynchronously, released through a synchronizer.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  ctl_rw_t          ctl;
  logic [CNT_W-1:0] cmp_val;
  logic             cond;
  logic             stat;

  cmp_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .ctl_o     (ctl),
    .cmp_o     (cmp_val)
  );

  cmp_timer_cond #(.CNT_W(CNT_W)) u_cond (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .count_i (count_i),
    .cmp_i   (cmp_val),
    .en_i    (ctl.en),
    .cond_o  (cond),
    .stat_o  (stat)
  );

  cmp_timer_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cond_i (cond),
    .en_i   (ctl.en),
    .mask_i (ctl.mask),
    .irq_o  (irq_o)
  );

  logic [CTL_W-1:0] ctl_word;
  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_EN_BIT]   = ctl.en;
    ctl_word[CTL_MASK_BIT] = ctl.mask;
    ctl_word[CTL_STAT_BIT] = stat;
    rd_data_o = (rd_sel_i == SEL_CMP) ? cmp_val : {{PAD_W{1'b0}}, ctl_word};
  end
endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] cmp_val,
  input logic             en,
  input logic             mask,
  input logic             stat,
  input logic             irq_o
);
  // R2 / R1: enabled flag equals the condition seen on the previous cycle
  assert_stat_tracks_cond_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(en) |-> (stat == ($past(count_i) >= $past(cmp_val))));

  // R3: a raised line implies a raised flag
  assert_irq_needs_stat_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> stat);

  // R3: a raised line implies enabled and unmasked one cycle earlier
  assert_irq_needs_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> $past(en && !mask));

  // R4: masked on the previous cycle means the line is low
  assert_mask_silences_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(mask) |-> !irq_o);

  // R6: disabled on the previous cycle means line low and flag frozen
  assert_disable_holds_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(!en) |-> (!irq_o && $stable(stat)));
endmodule

bind cmp_timer_chan cmp_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .count_i   (count_i),
  .cmp_val   (cmp_val),
  .en        (ctl.en),
  .mask      (ctl.mask),
  .stat      (stat),
  .irq_o     (irq_o)
);

// File: tb/cmp_timer_chan_tb_top.sv
module cmp_timer_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 64;

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] count_i;
  logic             wr_en_i;
  logic             wr_sel_i;
  logic [CNT_W-1:0] wr_data_i;
  logic             rd_sel_i;
  logic [CNT_W-1:0] rd_data_o;
  logic             irq_o;

  int total;
  int fails;
  bit done;

  cmp_timer_chan #(.CNT_W(CNT_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_i   (count_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic reg_write(input logic sel, input logic [63:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic reg_read(input logic sel, output logic [63:0] data);
    rd_sel_i = sel;
    #1;
    data = rd_data_o;
  endtask

  // Control word: bit0 enable, bit1 mask, bit2 status (read-only)
  task automatic t_reset();
    logic [63:0] v;
    check("R9 irq after reset", {63'b0, irq_o}, 64'd0);
    reg_read(1'b0, v); check("R9 control after reset", v, 64'd0);
    reg_read(1'b1, v); check("R9 compare after reset", v, 64'd0);
  endtask

  task automatic t_program();
    logic [63:0] v;
    count_i = 64'd0;
    reg_write(1'b1, 64'd100);
    reg_read(1'b1, v); check("R10 compare readback", v, 64'd100);
    reg_write(1'b0, 64'b101);          // bit 2 set but must be ignored
    step();
    reg_read(1'b0, v); check("R7 bit2 write ignored", v, 64'b001);
    check("R3 no irq below compare", {63'b0, irq_o}, 64'd0);
  endtask

  task automatic t_equal_boundary();
    logic [63:0] v;
    count_i = 64'd99; step();
    reg_read(1'b0, v); check("R1 count one below compare", v, 64'b001);
    count_i = 64'd100;
    #1; check("R3 irq not yet (registered)", {63'b0, irq_o}, 64'd0);
    step();
    reg_read(1'b0, v); check("R1 equality meets condition", v, 64'b101);
    check("R3 irq one cycle after cause", {63'b0, irq_o}, 64'd1);
  endtask

  task automatic t_mask();
    logic [63:0] v;
    reg_write(1'b0, 64'b011);
    check("R3 irq still high on mask write edge", {63'b0, irq_o}, 64'd1);
    step();
    check("R4 mask drops irq", {63'b0, irq_o}, 64'd0);
    reg_read(1'b0, v); check("R4 status kept while masked", v, 64'b111);
    count_i = 64'd50; step();
    reg_read(1'b0, v); check("R2 masked status follows low count", v, 64'b011);
    count_i = 64'd200; step();
    reg_read(1'b0, v); check("R2 masked status follows high count", v, 64'b111);
    check("R4 irq stays low while masked", {63'b0, irq_o}, 64'd0);
  endtask

  task automatic t_unmask();
    reg_write(1'b0, 64'b001);
    step();
    check("R8 unmask reasserts irq", {63'b0, irq_o}, 64'd1);
  endtask

  task automatic t_raise_compare();
    logic [63:0] v;
    reg_write(1'b1, 64'd300);
    check("R10 new compare not used on write edge", {63'b0, irq_o}, 64'd1);
    step();
    check("R5 irq cleared after compare raised", {63'b0, irq_o}, 64'd0);
    reg_read(1'b0, v); check("R5 status cleared", v, 64'b001);
  endtask

  task automatic t_disable();
    logic [63:0] v;
    reg_write(1'b1, 64'd150);
    step();
    check("R1 status up after lower compare", {63'b0, irq_o}, 64'd1);
    reg_write(1'b0, 64'b000);
    step();
    check("R6 disable drops irq", {63'b0, irq_o}, 64'd0);
    reg_read(1'b0, v); check("R6 status held on disable", v, 64'b100);
    count_i = 64'd0; step(); step();
    reg_read(1'b0, v); check("R6 status frozen while disabled", v, 64'b100);
    check("R6 irq low while disabled", {63'b0, irq_o}, 64'd0);
    reg_write(1'b0, 64'b001);
    step();
    reg_read(1'b0, v); check("R2 status re-evaluated on enable", v, 64'b001);
  endtask

  initial begin
    total = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; count_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0;
    wr_data_i = '0; rd_sel_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_equal_boundary();
    t_mask();
    t_unmask();
    t_raise_compare();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule